// File: doc/BRIEF.md
# Region-Aware XY Output Selector

This block picks the output port of a 2D-mesh router that routes on minimal adaptive paths. When a packet still has distance to cover along both axes, there are two productive ports, one along X and one along Y. The block chooses between them from one of two congestion measures. When the destination is close to the current node, it uses the buffer fill reported by the adjacent routers. When the destination is far away, it uses the aggregated congestion level of the neighbouring clusters. The choice is computed from the coordinates and the congestion inputs alone, with no routing table.

Nodes are grouped into square clusters of 2^CLU_SHIFT by 2^CLU_SHIFT nodes. A node's cluster index on an axis is its coordinate shifted right by CLU_SHIFT. A request is accepted while `inValid` is high. The chosen port appears one clock later as a one-hot vector, with `portValid` set.

Top module: `xy_region_sel`

## Requirements
- R1: While `rstN` is low, and on the first sampled cycle after it rises, `portValid` is 0 and `portOut` is all zero.
- R2: The output is registered. A request presented with `inValid` high sets `portValid` to 1 on the next clock edge, with the chosen port. A cycle with `inValid` low leaves `portValid` at 0 and `portOut` at zero after the next edge.
- R3: `portOut` is one-hot with this bit order: bit0 Local, bit1 North (+Y), bit2 East (+X), bit3 South (−Y), bit4 West (−X). When the destination equals the current node, the Local bit (5'b00001) is selected.
- R4: When only one axis differs between current and destination coordinates, the single productive port on that axis is selected, whatever the congestion inputs are.
- R5: Near case. When the two nodes' cluster indices are at most 1 apart on X, or at most 1 apart on Y, the block compares the occupancy of the productive X neighbour (`occEast` or `occWest`) with that of the productive Y neighbour (`occNorth` or `occSouth`). The lower count wins, and the cluster congestion inputs have no effect.
- R6: Far case. When the cluster indices differ by 2 or more on both axes, the block compares the congestion of the cluster in the productive X direction with that of the cluster in the productive Y direction. The lower level wins, and the occupancy inputs have no effect.
- R7: On equal occupancy in the near case, or equal cluster congestion in the far case, the X port is chosen.
- R8: Whenever `portValid` is 1, exactly one bit of `portOut` is set, and it names a productive port of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| curX | input | COORD_W | X coordinate of this router |
| curY | input | COORD_W | Y coordinate of this router |
| dstX | input | COORD_W | Destination X coordinate |
| dstY | input | COORD_W | Destination Y coordinate |
| occEast | input | OCC_W | Occupied cells in the east neighbour's input buffer |
| occWest | input | OCC_W | Occupied cells in the west neighbour's input buffer |
| occNorth | input | OCC_W | Occupied cells in the north neighbour's input buffer |
| occSouth | input | OCC_W | Occupied cells in the south neighbour's input buffer |
| congEast | input | CONG_W | Congestion level of the cluster to the east |
| congWest | input | CONG_W | Congestion level of the cluster to the west |
| congNorth | input | CONG_W | Congestion level of the cluster to the north |
| congSouth | input | CONG_W | Congestion level of the cluster to the south |
| portValid | output | 1 | Registered: portOut holds a decision |
| portOut | output | 5 | Registered one-hot chosen port |

## Verification
The far case is the hardest to reach. It needs both cluster distances to be at least 2, which in a 6x6 mesh with 2x2 clusters only happens between opposite corner clusters. The stimulus places source and destination in those corner clusters in all four diagonal orientations. In each far case the occupancy inputs are set to favour the opposite answer, so that a selector stuck in the near mode would pick the wrong port. The near cases are likewise loaded with congestion levels that contradict the occupancy answer.

// File: rtl/xy_region_pkg.sv
package xy_region_pkg;
  localparam int PORT_N = 5;
  localparam int P_LOCAL = 0;
  localparam int P_NORTH = 1;
  localparam int P_EAST  = 2;
  localparam int P_SOUTH = 3;
  localparam int P_WEST  = 4;

  // Flags handed from the datapath to the control
  typedef struct packed {
    logic atDest;
    logic hasX;
    logic hasY;
    logic goEast;
    logic goNorth;
    logic pickX;
  } routeFlags_t;
endpackage

// File: rtl/xy_region_dp.sv
module xy_region_dp
  import xy_region_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int OCC_W = 3,
  parameter int CONG_W = 4,
  parameter int CLU_SHIFT = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic [COORD_W-1:0] curX,
  input  logic [COORD_W-1:0] curY,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  input  logic [OCC_W-1:0] occEast,
  input  logic [OCC_W-1:0] occWest,
  input  logic [OCC_W-1:0] occNorth,
  input  logic [OCC_W-1:0] occSouth,
  input  logic [CONG_W-1:0] congEast,
  input  logic [CONG_W-1:0] congWest,
  input  logic [CONG_W-1:0] congNorth,
  input  logic [CONG_W-1:0] congSouth,
  output routeFlags_t flags
);
  localparam int CLU_W = COORD_W - CLU_SHIFT;

  logic goEast, goWest, goNorth, goSouth;
  logic [OCC_W-1:0] occX, occY;
  logic [CONG_W-1:0] congX, congY;
  logic [CLU_W-1:0] curCx, curCy, dstCx, dstCy, distCx, distCy;
  logic nearMode, nodePickX, cluPickX;

  always_comb begin
    goEast  = dstX > curX;
    goWest  = dstX < curX;
    goNorth = dstY > curY;
    goSouth = dstY < curY;
    occX  = goEast ? occEast : occWest;
    occY  = goNorth ? occNorth : occSouth;
    congX = goEast ? congEast : congWest;
    congY = goNorth ? congNorth : congSouth;
  end

  always_comb begin
    curCx = curX[COORD_W-1:CLU_SHIFT];
    curCy = curY[COORD_W-1:CLU_SHIFT];
    dstCx = dstX[COORD_W-1:CLU_SHIFT];
    dstCy = dstY[COORD_W-1:CLU_SHIFT];
    distCx = (curCx > dstCx) ? curCx - dstCx : dstCx - curCx;
    distCy = (curCy > dstCy) ? curCy - dstCy : dstCy - curCy;
    nearMode = (distCx <= CLU_W'(1)) || (distCy <= CLU_W'(1));
  end

  always_comb begin
    nodePickX = occX <= occY;
    cluPickX  = congX <= congY;
    flags.atDest  = !(goEast || goWest || goNorth || goSouth);
    flags.hasX    = goEast || goWest;
    flags.hasY    = goNorth || goSouth;
    flags.goEast  = goEast;
    flags.goNorth = goNorth;
    flags.pickX   = nearMode ? nodePickX : cluPickX;
  end

  // R7
  tie_prefers_x_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nearMode && occX == occY) || (!nearMode && congX == congY) |-> flags.pickX);

  // R5
  near_lower_occ_chk: assert property (@(posedge clk) disable iff (!rstN)
    nearMode && occX < occY |-> flags.pickX);

  // R6
  far_lower_cong_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nearMode && congY < congX |-> !flags.pickX);
endmodule

// File: rtl/xy_region_ctl.sv
module xy_region_ctl
  import xy_region_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  routeFlags_t flags,
  output logic portValid,
  output logic [PORT_N-1:0] portOut
);
  logic [PORT_N-1:0] choice;

  always_comb begin
    choice = '0;
    if (flags.atDest)
      choice[P_LOCAL] = 1'b1;
    else if (flags.hasX && (!flags.hasY || flags.pickX))
      choice[flags.goEast ? P_EAST : P_WEST] = 1'b1;
    else
      choice[flags.goNorth ? P_NORTH : P_SOUTH] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portValid <= 1'b0;
      portOut   <= '0;
    end else begin
      portValid <= inValid;
      portOut   <= inValid ? choice : '0;
    end
  end

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> portValid);

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !portValid |-> portOut == '0);

  // R8
  onehot_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    portValid |-> $countones(portOut) == 1);

  // R3
  local_at_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && flags.atDest |=> portOut[P_LOCAL]);

  // R4
  single_x_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && flags.hasX && !flags.hasY |=> (portOut[P_EAST] || portOut[P_WEST]));
endmodule

// File: rtl/xy_region_sel.sv
module xy_region_sel
  import xy_region_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int OCC_W = 3,
  parameter int CONG_W = 4,
  parameter int CLU_SHIFT = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic [COORD_W-1:0] curX,
  input  logic [COORD_W-1:0] curY,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  input  logic [OCC_W-1:0] occEast,
  input  logic [OCC_W-1:0] occWest,
  input  logic [OCC_W-1:0] occNorth,
  input  logic [OCC_W-1:0] occSouth,
  input  logic [CONG_W-1:0] congEast,
  input  logic [CONG_W-1:0] congWest,
  input  logic [CONG_W-1:0] congNorth,
  input  logic [CONG_W-1:0] congSouth,
  output logic portValid,
  output logic [4:0] portOut
);
  routeFlags_t flags;

  xy_region_dp #(
    .COORD_W(COORD_W), .OCC_W(OCC_W), .CONG_W(CONG_W), .CLU_SHIFT(CLU_SHIFT)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .curX(curX), .curY(curY), .dstX(dstX), .dstY(dstY),
    .occEast(occEast), .occWest(occWest), .occNorth(occNorth), .occSouth(occSouth),
    .congEast(congEast), .congWest(congWest), .congNorth(congNorth), .congSouth(congSouth),
    .flags(flags)
  );

  xy_region_ctl ctl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .flags(flags),
    .portValid(portValid), .portOut(portOut)
  );
endmodule

// File: tb/xy_region_sel_tb_top.sv
`timescale 1ns/1ps
module xy_region_sel_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] curX = '0, curY = '0, dstX = '0, dstY = '0;
  logic [2:0] occEast = '0, occWest = '0, occNorth = '0, occSouth = '0;
  logic [3:0] congEast = '0, congWest = '0, congNorth = '0, congSouth = '0;
  logic portValid;
  logic [4:0] portOut;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  xy_region_sel dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .curX(curX), .curY(curY), .dstX(dstX), .dstY(dstY),
    .occEast(occEast), .occWest(occWest), .occNorth(occNorth), .occSouth(occSouth),
    .congEast(congEast), .congWest(congWest), .congNorth(congNorth), .congSouth(congSouth),
    .portValid(portValid), .portOut(portOut)
  );

  localparam logic [4:0] LOC = 5'b00001, NO = 5'b00010, EA = 5'b00100,
                         SO = 5'b01000, WE = 5'b10000;
  localparam int NV = 14;
  // {cx,cy,dx,dy, oE,oW,oN,oS, cE,cW,cN,cS, expected}
  localparam logic [44:0] VEC [NV] = '{
    {3'd2,3'd2,3'd2,3'd2, 3'd5,3'd5,3'd5,3'd5, 4'd1,4'd1,4'd1,4'd1, LOC}, // R3
    {3'd1,3'd1,3'd4,3'd1, 3'd5,3'd0,3'd0,3'd0, 4'd15,4'd0,4'd0,4'd0, EA}, // R4
    {3'd3,3'd3,3'd3,3'd0, 3'd0,3'd0,3'd0,3'd5, 4'd0,4'd0,4'd0,4'd15, SO}, // R4
    {3'd4,3'd5,3'd0,3'd5, 3'd0,3'd5,3'd0,3'd0, 4'd0,4'd9,4'd0,4'd0, WE},  // R4
    {3'd2,3'd2,3'd3,3'd4, 3'd4,3'd0,3'd1,3'd0, 4'd0,4'd0,4'd15,4'd0, NO}, // R5
    {3'd2,3'd2,3'd3,3'd4, 3'd1,3'd0,3'd3,3'd0, 4'd15,4'd0,4'd0,4'd0, EA}, // R5
    {3'd2,3'd2,3'd3,3'd4, 3'd2,3'd0,3'd2,3'd0, 4'd9,4'd0,4'd1,4'd0, EA},  // R7 near tie
    {3'd3,3'd4,3'd1,3'd2, 3'd0,3'd5,3'd0,3'd2, 4'd0,4'd0,4'd0,4'd9, SO},  // R5
    {3'd0,3'd0,3'd5,3'd5, 3'd0,3'd0,3'd5,3'd0, 4'd9,4'd0,4'd3,4'd0, NO},  // R6
    {3'd0,3'd0,3'd5,3'd5, 3'd5,3'd0,3'd0,3'd0, 4'd2,4'd0,4'd7,4'd0, EA},  // R6
    {3'd1,3'd0,3'd5,3'd5, 3'd5,3'd0,3'd0,3'd0, 4'd6,4'd0,4'd6,4'd0, EA},  // R7 far tie
    {3'd5,3'd5,3'd0,3'd0, 3'd0,3'd0,3'd0,3'd5, 4'd0,4'd8,4'd0,4'd1, SO},  // R6
    {3'd5,3'd0,3'd0,3'd5, 3'd0,3'd5,3'd0,3'd0, 4'd0,4'd1,4'd4,4'd0, WE},  // R6
    {3'd0,3'd5,3'd4,3'd0, 3'd0,3'd0,3'd0,3'd0, 4'd12,4'd0,4'd0,4'd3, SO}  // R6
  };

  task automatic check(input string req, input logic v, input logic [4:0] p,
                       input logic ev, input logic [4:0] ep);
    total++;
    if (v !== ev || p !== ep) begin
      bad++;
      $display("FAIL %s: got valid=%0b port=%05b, want valid=%0b port=%05b",
               req, v, p, ev, ep);
    end
  endtask

  initial begin
    #100000;
    bad++;
    $display("FAIL watchdog: got timeout, want finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", portValid, portOut, 1'b0, 5'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", portValid, portOut, 1'b0, 5'b0);

    for (int i = 0; i < NV; i++) begin
      {curX, curY, dstX, dstY, occEast, occWest, occNorth, occSouth,
       congEast, congWest, congNorth, congSouth} = VEC[i][44:5];
      inValid = 1'b1;
      @(negedge clk);
      check($sformatf("R8 vector %0d", i), portValid, portOut, 1'b1, VEC[i][4:0]);
    end

    // R2: idle cycle clears output
    inValid = 1'b0;
    @(negedge clk);
    check("R2 idle", portValid, portOut, 1'b0, 5'b0);

    // R2: one-cycle latency, input change while idle has no effect
    {curX, curY, dstX, dstY} = {3'd1, 3'd1, 3'd1, 3'd3};
    @(negedge clk);
    check("R2 still idle", portValid, portOut, 1'b0, 5'b0);
    inValid = 1'b1;
    @(negedge clk);
    check("R2 accepted", portValid, portOut, 1'b1, NO);
    inValid = 1'b0;

    // R1: reset mid-stream clears output
    {curX, curY, dstX, dstY} = {3'd0, 3'd0, 3'd5, 3'd0};
    inValid = 1'b1;
    @(negedge clk);
    check("R4 west-east", portValid, portOut, 1'b1, EA);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset", portValid, portOut, 1'b0, 5'b0);
    rstN = 1'b1;
    inValid = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule